// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two N-bit buses, called A and B, through a pair of storage registers. Each direction has its own capture strobe, source select and output enable. The A-to-B path drives bus B with either the live word from bus A or the contents of the A-side register. The B-to-A path does the same for bus A from the B side. The A-to-B enable is active high and the B-to-A enable is active low. Neither bus is modelled as a true tri-state pin. Each bus appears as an input word, an output word and an output-enable flag, and the chip's pad logic merges them.

The capture strobes are sampled on the core clock `clk`. A register loads at the first `clk` edge that sees its strobe high after seeing it low at the previous edge. The register takes the value actually present on its bus. When the block itself drives that bus, that value is the driven word and not the external input. If both directions are enabled while either select asks for live data, the buses would form a combinational loop. The block prevents this by forcing stored data in the offending direction and raising an error flag. An optional synchronous reset clears both registers and leaves the enables alone.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high (and `HAS_RESET` is 1), both storage registers clear to zero at the next `clk` edge, and a strobe edge in that cycle is ignored. `b_oe` still equals `oe_ab` and `a_oe` still equals `!oe_ba_n` during reset.
- R2: When `oe_ab` is 0, `b_oe` is 0. When `oe_ba_n` is 1, `a_oe` is 0. With `oe_ab`=0 and `oe_ba_n`=1, neither bus is driven.
- R3: With `sel_ab`=0 and no loop condition, `b_out` equals `a_in` in the same cycle. With `sel_ba`=0 and no loop condition, `a_out` equals `b_in`.
- R4: With `sel_ab`=1, `b_out` equals the A-side register. With `sel_ba`=1, `a_out` equals the B-side register.
- R5: A register loads only at a `clk` edge where its strobe is 1 and was 0 at the previous edge. This holds whatever the selects and enables are. A strobe held high loads nothing further.
- R6: Both strobes may rise together, and then each register captures its own bus in the same cycle.
- R7: With A passing live to B (`oe_ab`=1, `sel_ab`=0), a rising `cap_b` loads the live A word into the B-side register. The mirror case loads the live B word into the A-side register.
- R8: With `oe_ab`=1, `oe_ba_n`=0 and both selects 1, stored A drives B and stored B drives A at once, and `loop_err` is 0. A simultaneous capture then exchanges the two registers.
- R9: `loop_err` is 1 exactly when `oe_ab`=1, `oe_ba_n`=0 and at least one select is 0. While it is 1, `b_out` equals the A-side register and `a_out` equals the B-side register.
- R10: When a bus is driven by the block (its `_oe` is 1), that bus's register captures the driven output word and not the input word.
- R11: When a select changes, the enabled output is the newly selected source in that same cycle. At no time is it anything other than the live or the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high clear of both storage registers |
| a_in | input | W | Word currently on bus A from outside |
| b_in | input | W | Word currently on bus B from outside |
| cap_a | input | 1 | A-side capture strobe; rising edge loads bus A |
| cap_b | input | 1 | B-side capture strobe; rising edge loads bus B |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| oe_ab | input | 1 | A-to-B drive enable, active high |
| oe_ba_n | input | 1 | B-to-A drive enable, active low |
| a_out | output | W | Word the block drives onto bus A |
| a_oe | output | 1 | Bus A driven by the block |
| b_out | output | W | Word the block drives onto bus B |
| b_oe | output | 1 | Bus B driven by the block |
| loop_err | output | 1 | Both directions enabled with a live select; stored data forced |

## Verification
The bench targets the cases that hinge on feedback and ordering. In the first, the live A word passes to B while B's strobe rises, and R7 fails if the B register samples `b_in` instead of the driven word. In the second, both directions are enabled with both selects stored and both strobes rise together; a design that reads its own new value, or the external inputs, does not exchange the registers as R8 requires. Each of the three loop configurations (select A live, select B live, both live) must raise `loop_err` and fall back to stored data; a design that passes live data there has a real loop and wrong outputs. Further tests hold a strobe high across several cycles and raise it during reset. A design that loads on level, or lets the strobe beat the reset, shows a changed stored word afterwards.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned DEF_WIDTH = 8;

    // Drive decision for one direction of the channel.
    typedef struct packed {
        logic drive;      // output enable toward the far bus
        logic use_store;  // 1: register contents, 0: live opposite bus
    } dir_ctl_t;

    // Resolve one direction: a requested live path is overridden with
    // stored data whenever both directions are driving.
    function automatic dir_ctl_t resolve_dir(input logic enable,
                                             input logic want_store,
                                             input logic both_on);
        dir_ctl_t r;
        r.drive     = enable;
        r.use_store = want_store | both_on;
        return r;
    endfunction

endpackage

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
(
    input  logic     oe_ab,
    input  logic     oe_ba_n,
    input  logic     sel_ab,
    input  logic     sel_ba,
    output dir_ctl_t ab_ctl,
    output dir_ctl_t ba_ctl,
    output logic     loop_err
);

    logic ab_on;
    logic ba_on;
    logic both_on;

    always_comb begin
        ab_on    = oe_ab;
        ba_on    = ~oe_ba_n;
        both_on  = ab_on & ba_on;
        ab_ctl   = resolve_dir(ab_on, sel_ab, both_on);
        ba_ctl   = resolve_dir(ba_on, sel_ba, both_on);
        loop_err = both_on & (~sel_ab | ~sel_ba);
    end

endmodule

// File: rtl/xcvr_lane_mux.sv
module xcvr_lane_mux #(
    parameter int unsigned W = 8
) (
    input  logic         use_store,
    input  logic [W-1:0] live_word,
    input  logic [W-1:0] held_word,
    output logic [W-1:0] out_word
);

    // One identical selector per bit lane.
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign out_word[i] = use_store ? held_word[i] : live_word[i];
    end

endmodule

// File: rtl/xcvr_edge_store.sv
module xcvr_edge_store #(
    parameter int unsigned W         = 8,
    parameter bit          HAS_RESET = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic strobe_prev;
    logic fire;

    always_ff @(posedge clk) begin
        strobe_prev <= strobe;
    end

    assign fire = strobe & ~strobe_prev;

    if (HAS_RESET) begin : g_rst
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (fire) begin
                q <= d;
            end
        end
    end else begin : g_norst
        always_ff @(posedge clk) begin
            if (fire) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int unsigned W         = DEF_WIDTH,
    parameter bit          HAS_RESET = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         loop_err
);

    dir_ctl_t     ab_ctl;
    dir_ctl_t     ba_ctl;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic [W-1:0] bus_a_now;
    logic [W-1:0] bus_b_now;

    xcvr_route u_route (
        .oe_ab    (oe_ab),
        .oe_ba_n  (oe_ba_n),
        .sel_ab   (sel_ab),
        .sel_ba   (sel_ba),
        .ab_ctl   (ab_ctl),
        .ba_ctl   (ba_ctl),
        .loop_err (loop_err)
    );

    xcvr_lane_mux #(.W(W)) u_mux_ab (
        .use_store (ab_ctl.use_store),
        .live_word (a_in),
        .held_word (a_q),
        .out_word  (b_out)
    );

    xcvr_lane_mux #(.W(W)) u_mux_ba (
        .use_store (ba_ctl.use_store),
        .live_word (b_in),
        .held_word (b_q),
        .out_word  (a_out)
    );

    assign b_oe = ab_ctl.drive;
    assign a_oe = ba_ctl.drive;

    // Resolved bus value: what a real bus would carry this cycle.
    assign bus_a_now = a_oe ? a_out : a_in;
    assign bus_b_now = b_oe ? b_out : b_in;

    xcvr_edge_store #(.W(W), .HAS_RESET(HAS_RESET)) u_store_a (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_a),
        .d      (bus_a_now),
        .q      (a_q)
    );

    xcvr_edge_store #(.W(W), .HAS_RESET(HAS_RESET)) u_store_b (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_b),
        .d      (bus_b_now),
        .q      (b_q)
    );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
    parameter int unsigned W         = 8,
    parameter bit          HAS_RESET = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         cap_a,
    input logic         cap_b,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         loop_err,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q
);

    if (HAS_RESET) begin : g_rst_chk
        assert_reset_clear_R1: assert property (@(posedge clk)
            rst |=> (a_q == '0 && b_q == '0));
    end

    assert_enable_follow_R1: assert property (@(posedge clk)
        (b_oe == oe_ab) && (a_oe == !oe_ba_n));

    assert_isolate_ab_R2: assert property (@(posedge clk) disable iff (rst)
        !oe_ab |-> !b_oe);
    assert_isolate_ba_R2: assert property (@(posedge clk) disable iff (rst)
        oe_ba_n |-> !a_oe);

    assert_live_ab_R3: assert property (@(posedge clk) disable iff (rst)
        (b_oe && !a_oe && !sel_ab) |-> b_out == a_in);
    assert_live_ba_R3: assert property (@(posedge clk) disable iff (rst)
        (a_oe && !b_oe && !sel_ba) |-> a_out == b_in);

    assert_stored_ab_R4: assert property (@(posedge clk) disable iff (rst)
        (b_oe && sel_ab) |-> b_out == a_q);

    // Capture of the resolved bus value covers R5, R7 and R10.
    assert_capture_a_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_a) |=> a_q == $past(a_oe ? a_out : a_in));
    assert_capture_b_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_b) |=> b_q == $past(b_oe ? b_out : b_in));
    assert_hold_a_R5: assert property (@(posedge clk) disable iff (rst)
        !$rose(cap_a) |=> $stable(a_q));
    assert_hold_b_R5: assert property (@(posedge clk) disable iff (rst)
        !$rose(cap_b) |=> $stable(b_q));

    assert_loop_flag_R9: assert property (@(posedge clk) disable iff (rst)
        loop_err |-> (b_oe && a_oe && !(sel_ab && sel_ba)));
    assert_loop_force_R9: assert property (@(posedge clk) disable iff (rst)
        loop_err |-> (b_out == a_q && a_out == b_q));
    assert_cross_ok_R8: assert property (@(posedge clk) disable iff (rst)
        (oe_ab && !oe_ba_n && sel_ab && sel_ba) |-> !loop_err);

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
        b_oe |-> (b_out == a_q || b_out == a_in));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W), .HAS_RESET(HAS_RESET)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .b_in     (b_in),
    .cap_a    (cap_a),
    .cap_b    (cap_b),
    .sel_ab   (sel_ab),
    .sel_ba   (sel_ba),
    .oe_ab    (oe_ab),
    .oe_ba_n  (oe_ba_n),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .loop_err (loop_err),
    .a_q      (a_q),
    .b_q      (b_q)
);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;

    localparam int unsigned W  = 8;
    localparam time         HP = 4ns;
    localparam int          NV = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         cap_a, cap_b, sel_ab, sel_ba, oe_ab, oe_ba_n;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, loop_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #HP clk = ~clk;

    bus_xcvr_reg #(.W(W), .HAS_RESET(1'b1)) i_bus_xcvr_reg (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .b_in     (b_in),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .sel_ab   (sel_ab),
        .sel_ba   (sel_ba),
        .oe_ab    (oe_ab),
        .oe_ba_n  (oe_ba_n),
        .a_out    (a_out),
        .a_oe     (a_oe),
        .b_out    (b_out),
        .b_oe     (b_oe),
        .loop_err (loop_err)
    );

    typedef struct packed {
        logic         oe_ab, oe_ba_n, sel_ab, sel_ba, cap_a, cap_b;
        logic [W-1:0] a, b;
        logic         x_boe;
        logic [W-1:0] x_b;
        logic         x_aoe;
        logic [W-1:0] x_a;
        logic         x_err;
    } vec_t;

    // Outputs are checked before the clock edge that ends each step.
    localparam vec_t TBL [NV] = '{
        '{0,1,0,0,0,0,8'h11,8'h22, 0,8'h00,0,8'h00,0}, // R2 isolation
        '{0,1,0,0,1,1,8'h33,8'h44, 0,8'h00,0,8'h00,0}, // R6 both load while isolated
        '{1,0,1,1,1,1,8'h55,8'h66, 1,8'h33,1,8'h44,0}, // R5 held strobes: no reload
        '{1,1,0,0,0,0,8'h77,8'h88, 1,8'h77,0,8'h00,0}, // R3 live A to B
        '{1,1,0,0,0,1,8'h99,8'hAA, 1,8'h99,0,8'h00,0}, // R7 B reg takes live A
        '{0,0,0,1,0,0,8'hBB,8'hCC, 0,8'h00,1,8'h99,0}, // R7 stored shows A word
        '{0,0,0,0,1,0,8'hDD,8'hEE, 0,8'h00,1,8'hEE,0}, // R10 A reg takes driven word
        '{1,1,1,0,0,0,8'h01,8'h02, 1,8'hEE,0,8'h00,0}, // R4 stored A to B
        '{1,0,1,1,0,0,8'h03,8'h04, 1,8'hEE,1,8'h99,0}, // R8 cross drive
        '{1,0,1,1,1,1,8'h03,8'h04, 1,8'hEE,1,8'h99,0}, // R8 simultaneous load
        '{1,0,1,1,0,0,8'h03,8'h04, 1,8'h99,1,8'hEE,0}, // R8 contents exchanged
        '{1,0,0,1,0,0,8'h05,8'h06, 1,8'h99,1,8'hEE,1}, // R9 A-to-B live requested
        '{1,0,0,0,0,0,8'h05,8'h06, 1,8'h99,1,8'hEE,1}, // R9 both live requested
        '{1,0,1,0,0,0,8'h05,8'h06, 1,8'h99,1,8'hEE,1}, // R9 B-to-A live requested
        '{1,1,0,1,0,0,8'h12,8'h34, 1,8'h12,0,8'h00,0}, // R11 live before switch
        '{1,1,1,1,0,0,8'h12,8'h34, 1,8'h99,0,8'h00,0}  // R11 stored right after switch
    };

    function automatic string tag_of(input int idx);
        case (idx)
            0:            return "R2";
            1:            return "R6";
            2:            return "R5";
            3:            return "R3";
            4, 5:         return "R7";
            6:            return "R10";
            7:            return "R4";
            8, 9, 10:     return "R8";
            11, 12, 13:   return "R9";
            default:      return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        oe_ab   = v.oe_ab;
        oe_ba_n = v.oe_ba_n;
        sel_ab  = v.sel_ab;
        sel_ba  = v.sel_ba;
        cap_a   = v.cap_a;
        cap_b   = v.cap_b;
        a_in    = v.a;
        b_in    = v.b;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(HP * 2 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        apply('{0,1,0,0,0,0,8'h00,8'h00, 0,8'h00,0,8'h00,0});
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            #1;
            chk(tag_of(i), "b_oe", 32'(b_oe), 32'(TBL[i].x_boe));
            chk(tag_of(i), "a_oe", 32'(a_oe), 32'(TBL[i].x_aoe));
            chk(tag_of(i), "loop_err", 32'(loop_err), 32'(TBL[i].x_err));
            if (TBL[i].x_boe) chk(tag_of(i), "b_out", 32'(b_out), 32'(TBL[i].x_b));
            if (TBL[i].x_aoe) chk(tag_of(i), "a_out", 32'(a_out), 32'(TBL[i].x_a));
        end

        // R1: reset asserted together with rising strobes; enables unaffected.
        @(negedge clk);
        rst = 1'b1;
        apply('{1,0,1,1,1,1,8'h5A,8'hA5, 0,8'h00,0,8'h00,0});
        #1;
        chk("R1", "b_oe in reset", 32'(b_oe), 32'd1);
        chk("R1", "a_oe in reset", 32'(a_oe), 32'd1);
        @(negedge clk);
        chk("R1", "b_out cleared", 32'(b_out), 32'h00);
        chk("R1", "a_out cleared", 32'(a_out), 32'h00);

        // R5: strobes stay high after reset release, so nothing loads.
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R5", "b_out held high strobe", 32'(b_out), 32'h00);
        chk("R5", "a_out held high strobe", 32'(a_out), 32'h00);

        // R3: live B to A with isolation of the other direction.
        oe_ab = 1'b0; sel_ba = 1'b0; cap_a = 1'b0; cap_b = 1'b0; b_in = 8'h6C;
        #1;
        chk("R3", "a_out live B", 32'(a_out), 32'h6C);
        chk("R2", "b_oe off", 32'(b_oe), 32'd0);

        @(negedge clk);
        finish_run();
    end

endmodule